// File: doc/BRIEF.md
# Bus-Snooping Page Mailbox Responder

This block sits on a simplified host bus and watches every request. A request is claimed only when its address falls inside one configurable 4 KB communication page. The block then passes data and arguments to a function unit and returns that unit's results to the host. Within a claimed address, the twelve bits below the page boundary do not select a location. They carry encoded arguments for the function.

A claimed write is handled like write-through traffic. The block latches the argument bits and the write data, then pulses a start strobe toward the function unit. It leaves the data bus alone. A claimed read is answered as if a snooping cache held a modified copy of the line. The block raises a modified-hit snoop response and then drives a whole 32-byte line as four 64-bit beats. While the beats are driven, an absorb strobe tells the memory side to take the line as a writeback. If no valid result is held when a read arrives, the block stretches the snoop phase with a stall signal until one is delivered.

Three saturating counters record claimed reads, claimed writes and stall cycles for performance study.

Top module: `snoop_page_mailbox`

## Requirements
- R1: A request is claimed only when host_addr[31:12] equals page_base. Any other request produces no snoop response, no stall, no beat, no start strobe and no counter change.
- R2: host_cmd 2'b01 is a line read and 2'b11 is a write. Codes 2'b00 and 2'b10 are never claimed, even inside the page.
- R3: In the cycle after a claimed write, fn_start is high for one cycle, fn_args holds host_addr[11:0] of that write and fn_wdata holds its host_wdata. The write drives no snoop or data output.
- R4: When a valid result is held, or res_valid is high in the same cycle as the request, a claimed read raises snoop_hitm for exactly one cycle, in the cycle after the request.
- R5: In the four cycles right after snoop_hitm, line_valid and mem_absorb are both high, one beat per cycle. After that the block is idle again.
- R6: Beats go out critical word first. Beat k carries 64-bit chunk (host_addr[4:3] + k) mod 4 of the line. Chunk 0 is the latest result, zero-extended, and chunks 1 to 3 are zero.
- R7: A claimed read with no valid result held raises snoop_stall from the next cycle until the cycle in which res_valid is seen, and snoop_hitm follows in the next cycle. A claimed write clears the held-result flag and res_valid sets it, capturing res_data.
- R8: cnt_rd and cnt_wr count claimed reads and writes, and cnt_stall counts cycles with snoop_stall high. Each one rises by one per event and stops at its maximum.
- R9: While a read is in progress (stall, snoop hit or beats), new requests are not claimed and not counted.
- R10: A synchronous reset clears the counters, returns the sequencer to idle and clears the held-result flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| page_base | input | ADDR_W-PAGE_BITS | Page number of the communication page |
| host_req | input | 1 | Request present this cycle |
| host_addr | input | ADDR_W | Request address |
| host_cmd | input | 2 | Command code |
| host_wdata | input | DATA_W | Write data of the request |
| snoop_hitm | output | 1 | Modified-hit snoop response |
| snoop_stall | output | 1 | Snoop phase held, result pending |
| line_valid | output | 1 | Line beat driven this cycle |
| line_data | output | DATA_W | Line beat data |
| mem_absorb | output | 1 | Memory side captures this beat as writeback |
| fn_start | output | 1 | Start strobe toward the function unit |
| fn_args | output | PAGE_BITS | Arguments taken from the low address bits |
| fn_wdata | output | DATA_W | Write data passed to the function unit |
| res_valid | input | 1 | Result delivered this cycle |
| res_data | input | RES_W | Result value |
| cnt_rd | output | CNT_W | Claimed read count |
| cnt_wr | output | CNT_W | Claimed write count |
| cnt_stall | output | CNT_W | Stall cycle count |

## Verification
The hardest case to reach is a request that arrives while a read is still being answered. The bench issues an in-page write one cycle after a read, while the sequencer is busy. It then checks that neither the write counter nor the start strobe moves. A second hard case is a read that arrives after reset, or after a write, with no result held. The bench holds back res_valid for several cycles so that the stall phase lasts long enough to be observed. The bench is built with three-bit counters, so that a burst of back-to-back writes drives the write counter into saturation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [1:0] CMD_LINE_RD = 2'b01;
  localparam logic [1:0] CMD_WR      = 2'b11;
  localparam int LINE_BEATS = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STALL = 2'd1,
    SEQ_HITM  = 2'd2,
    SEQ_BEAT  = 2'd3
  } seq_state_t;

  function automatic logic is_read_cmd(input logic [1:0] cmd);
    return cmd == CMD_LINE_RD;
  endfunction

  function automatic logic is_write_cmd(input logic [1:0] cmd);
    return cmd == CMD_WR;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int BASE_W   = ADDR_W - PAGE_BITS
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmd,
  input  logic [BASE_W-1:0] base,
  input  logic              accept_en,
  output logic              in_page,
  output logic              claim_rd,
  output logic              claim_wr
);

  function automatic logic page_hit(input logic [ADDR_W-1:0] a, input logic [BASE_W-1:0] b);
    return a[ADDR_W-1:PAGE_BITS] == b;
  endfunction

  always_comb begin
    in_page  = req && page_hit(addr, base);
    claim_rd = in_page && accept_en && is_read_cmd(cmd);
    claim_wr = in_page && accept_en && is_write_cmd(cmd);
  end

endmodule

// File: rtl/mbx_arg_latch.sv
module mbx_arg_latch #(
  parameter int PAGE_BITS = 12,
  parameter int DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 claim_wr,
  input  logic [PAGE_BITS-1:0] addr_low,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 fn_start,
  output logic [PAGE_BITS-1:0] fn_args,
  output logic [DATA_W-1:0]    fn_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_start <= 1'b0;
      fn_args  <= '0;
      fn_wdata <= '0;
    end else begin
      fn_start <= claim_wr;
      if (claim_wr) begin
        fn_args  <= addr_low;
        fn_wdata <= wdata;
      end
    end
  end

endmodule

// File: rtl/mbx_line_seq.sv
module mbx_line_seq
  import mbx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int RES_W  = 64,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_rd,
  input  logic              claim_wr,
  input  logic [IDX_W-1:0]  crit_idx,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              seq_idle,
  output logic              snoop_hitm,
  output logic              snoop_stall,
  output logic              line_valid,
  output logic              mem_absorb,
  output logic [DATA_W-1:0] line_data
);

  localparam int LAST_BEAT = (1 << IDX_W) - 1;

  seq_state_t        state_q;
  logic [IDX_W-1:0]  beat_q;
  logic [IDX_W-1:0]  crit_q;
  logic              have_res_q;
  logic [DATA_W-1:0] res_q;
  logic              res_ready;
  logic              last_beat;

  function automatic logic [DATA_W-1:0] beat_word(input logic [IDX_W-1:0] crit,
                                                  input logic [IDX_W-1:0] beat,
                                                  input logic [DATA_W-1:0] res);
    logic [IDX_W-1:0] chunk;
    chunk = crit + beat;
    return (chunk == '0) ? res : '0;
  endfunction

  assign res_ready = have_res_q || res_valid;
  assign last_beat = beat_q == IDX_W'(LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_res_q <= 1'b0;
      res_q      <= '0;
    end else if (res_valid) begin
      have_res_q <= 1'b1;
      res_q      <= DATA_W'(res_data);
    end else if (claim_wr) begin
      have_res_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      beat_q  <= '0;
      crit_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (claim_rd) begin
            crit_q  <= crit_idx;
            state_q <= res_ready ? SEQ_HITM : SEQ_STALL;
          end
        end
        SEQ_STALL: begin
          if (res_valid) state_q <= SEQ_HITM;
        end
        SEQ_HITM: begin
          beat_q  <= '0;
          state_q <= SEQ_BEAT;
        end
        SEQ_BEAT: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    seq_idle    = state_q == SEQ_IDLE;
    snoop_stall = state_q == SEQ_STALL;
    snoop_hitm  = state_q == SEQ_HITM;
    line_valid  = state_q == SEQ_BEAT;
    mem_absorb  = state_q == SEQ_BEAT;
    line_data   = line_valid ? beat_word(crit_q, beat_q, res_q) : '0;
  end

  AST_HITM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    snoop_hitm |=> !snoop_hitm && line_valid) else $error("hitm not single"); // R5
  AST_STALL_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(snoop_stall) |-> snoop_hitm) else $error("stall exit"); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (snoop_stall && !res_valid) |=> snoop_stall) else $error("stall hold"); // R7
  AST_BEAT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(line_valid) |-> $past(snoop_hitm)) else $error("beat start"); // R5

endmodule

// File: rtl/mbx_sat_counter.sv
module mbx_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == MAXV) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (inc) cnt_q <= bump(cnt_q);
  end

  assign cnt = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV) |=> (cnt_q == MAXV)) else $error("counter wrapped"); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + W'(1))) else $error("bad step"); // R8

endmodule

// File: rtl/snoop_page_mailbox.sv
module snoop_page_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int DATA_W    = 64,
  parameter int RES_W     = 64,
  parameter int CNT_W     = 32,
  localparam int BASE_W   = ADDR_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(LINE_BEATS),
  localparam int OFF_W    = $clog2(DATA_W / 8)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BASE_W-1:0]    page_base,
  input  logic                 host_req,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [1:0]           host_cmd,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic                 snoop_hitm,
  output logic                 snoop_stall,
  output logic                 line_valid,
  output logic [DATA_W-1:0]    line_data,
  output logic                 mem_absorb,
  output logic                 fn_start,
  output logic [PAGE_BITS-1:0] fn_args,
  output logic [DATA_W-1:0]    fn_wdata,
  input  logic                 res_valid,
  input  logic [RES_W-1:0]     res_data,
  output logic [CNT_W-1:0]     cnt_rd,
  output logic [CNT_W-1:0]     cnt_wr,
  output logic [CNT_W-1:0]     cnt_stall
);

  localparam int N_CNT = 3;

  logic in_page;
  logic claim_rd;
  logic claim_wr;
  logic seq_idle;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  mbx_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dec (
    .req(host_req), .addr(host_addr), .cmd(host_cmd), .base(page_base),
    .accept_en(seq_idle), .in_page(in_page), .claim_rd(claim_rd), .claim_wr(claim_wr)
  );

  mbx_arg_latch #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_arg (
    .clk(clk), .rst(rst), .claim_wr(claim_wr), .addr_low(host_addr[PAGE_BITS-1:0]),
    .wdata(host_wdata), .fn_start(fn_start), .fn_args(fn_args), .fn_wdata(fn_wdata)
  );

  mbx_line_seq #(.DATA_W(DATA_W), .RES_W(RES_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .claim_rd(claim_rd), .claim_wr(claim_wr),
    .crit_idx(host_addr[OFF_W +: IDX_W]), .res_valid(res_valid), .res_data(res_data),
    .seq_idle(seq_idle), .snoop_hitm(snoop_hitm), .snoop_stall(snoop_stall),
    .line_valid(line_valid), .mem_absorb(mem_absorb), .line_data(line_data)
  );

  assign cnt_inc = {snoop_stall, claim_wr, claim_rd};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    mbx_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[g]), .cnt(cnt_arr[g])
    );
  end

  assign cnt_rd    = cnt_arr[0];
  assign cnt_wr    = cnt_arr[1];
  assign cnt_stall = cnt_arr[2];

  AST_WR_STARTS: assert property (@(posedge clk) disable iff (rst)
    claim_wr |=> fn_start) else $error("write without start"); // R3
  AST_RD_ANSWERS: assert property (@(posedge clk) disable iff (rst)
    claim_rd |=> (snoop_hitm || snoop_stall)) else $error("read unanswered"); // R4
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !in_page) |=> !(snoop_hitm || snoop_stall || fn_start)) else $error("outside claimed"); // R1

endmodule

// File: tb/sim_snoop_page_mailbox.sv
`timescale 1ns/1ps
module sim_snoop_page_mailbox;

  localparam int CW   = 3;
  localparam int MAXC = (1 << CW) - 1;
  localparam logic [19:0] BASE = 20'hA5C3E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic [31:0] host_addr = '0;
  logic [1:0]  host_cmd = 2'b00;
  logic [63:0] host_wdata = '0;
  logic        res_valid = 1'b0;
  logic [63:0] res_data = '0;
  logic        snoop_hitm, snoop_stall, line_valid, mem_absorb, fn_start;
  logic [63:0] line_data, fn_wdata;
  logic [11:0] fn_args;
  logic [CW-1:0] cnt_rd, cnt_wr, cnt_stall;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  snoop_page_mailbox #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .page_base(BASE), .host_req(host_req), .host_addr(host_addr),
    .host_cmd(host_cmd), .host_wdata(host_wdata), .snoop_hitm(snoop_hitm),
    .snoop_stall(snoop_stall), .line_valid(line_valid), .line_data(line_data),
    .mem_absorb(mem_absorb), .fn_start(fn_start), .fn_args(fn_args), .fn_wdata(fn_wdata),
    .res_valid(res_valid), .res_data(res_data), .cnt_rd(cnt_rd), .cnt_wr(cnt_wr),
    .cnt_stall(cnt_stall)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 waiting for result, 2 hit response, 3 beats
  bit    started = 0;
  int    ph = 0, beat = 0, crit = 0;
  bit    ok_res = 0;
  logic [63:0] res_m = '0;
  int    m_rd = 0, m_wr = 0, m_st = 0;
  bit    x_start = 0;
  logic [11:0] x_args = '0;
  logic [63:0] x_wd = '0;

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  always @(posedge clk) begin
    bit pg, rd, wr, wr_hit;
    started = 1;
    if (rst) begin
      ph = 0; beat = 0; crit = 0; ok_res = 0; res_m = '0;
      m_rd = 0; m_wr = 0; m_st = 0; x_start = 0;
    end else begin
      pg = host_req && (host_addr[31:12] == BASE);
      rd = pg && host_cmd == 2'b01;
      wr = pg && host_cmd == 2'b11;
      wr_hit = 0;
      x_start = 0;
      case (ph)
        0: if (rd) begin
             m_rd = sat(m_rd + 1);
             crit = int'(host_addr[4:3]);
             ph = (ok_res || res_valid) ? 2 : 1;
           end else if (wr) begin
             m_wr = sat(m_wr + 1);
             x_start = 1; x_args = host_addr[11:0]; x_wd = host_wdata;
             wr_hit = 1;
           end
        1: begin m_st = sat(m_st + 1); if (res_valid) ph = 2; end
        2: begin ph = 3; beat = 0; end
        default: begin if (beat == 3) ph = 0; else beat++; end
      endcase
      if (res_valid) begin res_m = res_data; ok_res = 1; end
      else if (wr_hit) ok_res = 0;
    end
  end

  always @(negedge clk) begin
    logic [63:0] xd;
    if (started) begin
      chk(snoop_hitm == (ph == 2), "R4 hitm", 64'(snoop_hitm), 64'(ph == 2));
      chk(snoop_stall == (ph == 1), "R7 stall", 64'(snoop_stall), 64'(ph == 1));
      chk(line_valid == (ph == 3), "R5 line_valid", 64'(line_valid), 64'(ph == 3));
      chk(mem_absorb == (ph == 3), "R5 mem_absorb", 64'(mem_absorb), 64'(ph == 3));
      if (ph == 3) begin
        xd = (((crit + beat) % 4) == 0) ? res_m : 64'd0;
        chk(line_data == xd, "R6 beat data", line_data, xd);
      end
      chk(fn_start == x_start, "R3 fn_start", 64'(fn_start), 64'(x_start));
      if (x_start) begin
        chk(fn_args == x_args, "R3 fn_args", 64'(fn_args), 64'(x_args));
        chk(fn_wdata == x_wd, "R3 fn_wdata", fn_wdata, x_wd);
      end
      chk(int'(cnt_rd) == m_rd, "R8 cnt_rd", 64'(cnt_rd), 64'(m_rd));
      chk(int'(cnt_wr) == m_wr, "R8 cnt_wr", 64'(cnt_wr), 64'(m_wr));
      chk(int'(cnt_stall) == m_st, "R8 cnt_stall", 64'(cnt_stall), 64'(m_st));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] c, input logic [63:0] d);
    host_req = 1'b1; host_addr = a; host_cmd = c; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_cmd = 2'b00;
  endtask

  task automatic give(input logic [63:0] d);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic settle();
    int guard = 0;
    while (ph != 0 && guard < 50) begin @(negedge clk); guard++; end
    cyc(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [CW-1:0] snap;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk(cnt_rd == 0 && cnt_wr == 0 && cnt_stall == 0, "R10 counters after reset", 64'(cnt_rd), 0);
    chk(!snoop_hitm && !line_valid, "R10 idle after reset", 64'(snoop_hitm), 0);

    // R3 write delivers args and data
    send({BASE, 12'hABC}, 2'b11, 64'h1122_3344_5566_7788);
    cyc(2);
    // R7 read with no result held: stall until result arrives
    send({BASE, 12'h008}, 2'b01, '0);
    cyc(4);
    chk(snoop_stall == 1'b1, "R7 stall held without result", 64'(snoop_stall), 1);
    give(64'hDEAD_BEEF_0000_0001);
    settle();

    // R6 each critical word position, result held
    for (int k = 0; k < 4; k++) begin
      send({BASE, 7'd0, 2'(k), 3'd0}, 2'b01, '0);
      settle();
    end
    // R4 result arriving in the same cycle as the read
    send({BASE, 12'h040}, 2'b11, 64'h5);
    host_req = 1'b1; host_addr = {BASE, 12'h018}; host_cmd = 2'b01;
    res_valid = 1'b1; res_data = 64'hCAFE_F00D_1234_5678;
    @(negedge clk);
    host_req = 1'b0; host_cmd = 2'b00; res_valid = 1'b0;
    chk(snoop_hitm == 1'b1, "R4 hitm with same-cycle result", 64'(snoop_hitm), 1);
    settle();

    // R1 outside the page
    snap = cnt_rd;
    send({BASE ^ 20'h1, 12'h000}, 2'b01, '0);
    send({BASE ^ 20'h80000, 12'h010}, 2'b11, 64'h9);
    cyc(3);
    chk(cnt_rd == snap, "R1 no count outside page", 64'(cnt_rd), 64'(snap));
    chk(!snoop_hitm && !fn_start, "R1 no response outside page", 64'(snoop_hitm), 0);

    // R2 unclaimed command codes
    snap = cnt_wr;
    send({BASE, 12'h020}, 2'b00, 64'h7);
    send({BASE, 12'h028}, 2'b10, 64'h7);
    cyc(2);
    chk(cnt_wr == snap, "R2 reserved codes not claimed", 64'(cnt_wr), 64'(snap));

    // R9 write during a read response
    give(64'h77);
    send({BASE, 12'h000}, 2'b01, '0);
    snap = cnt_wr;
    send({BASE, 12'h3F0}, 2'b11, 64'hAA);
    cyc(1);
    chk(cnt_wr == snap && !fn_start, "R9 write ignored while busy", 64'(cnt_wr), 64'(snap));
    settle();

    // R8 saturation of the write counter
    for (int k = 0; k < 10; k++) send({BASE, 12'(k * 8)}, 2'b11, 64'(k));
    cyc(2);
    chk(cnt_wr == CW'(MAXC), "R8 write counter saturates", 64'(cnt_wr), 64'(MAXC));

    // R10 reset mid-run clears counters and the held result
    give(64'h1234);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    cyc(1);
    chk(cnt_wr == 0 && cnt_rd == 0 && cnt_stall == 0, "R10 counters cleared", 64'(cnt_wr), 0);
    send({BASE, 12'h000}, 2'b01, '0);
    chk(snoop_stall == 1'b1, "R10 result flag cleared", 64'(snoop_stall), 1);
    cyc(2);
    give(64'h42);
    settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule